// File: doc/BRIEF.md
# Camera Pixel Output Formatter

This block sits at the end of an image pipeline and turns processed pixels into an 8-bit parallel video port. The port has a pixel clock, a frame strobe (`vsync_o`) and a line strobe (`hsync_o`). It accepts one pixel at a time through a hold-until-taken interface. The pixel is either a raw sensor sample, of which the top eight bits are sent, or a three-channel colour value. In the colour modes the pixel is packed into two bytes, as RGB565 or as 4:2:2 luma/chroma.

The pixel clock is the system clock divided by an integer `Np`. The requested divider is raised to the least value the mode allows. Every output change is launched together with a falling pixel clock edge, so a receiver can capture on the rising edge.

Format and divider are sampled once, at the start of each frame. Changes made while a frame is being sent do not reach that frame.

Top module: `cam_pix_fmt`

## Requirements
- R1: Format code 0 (raw) sends one byte per pixel, equal to `in_raw[9:2]`. Code 3 behaves exactly like code 0.
- R2: Format code 1 (RGB565) sends two bytes per pixel, with R=`in_c0`, G=`in_c1` and B=`in_c2`. The first byte is `{R[7:3], G[7:5]}` and the second is `{G[4:2], B[7:3]}`.
- R3: Format code 2 (YCbCr 4:2:2) sends two bytes per pixel, with Y=`in_c0`, Cb=`in_c1` and Cr=`in_c2`. Pixels at even positions of a line (counted from 0) send Y then Cb. Odd positions send Y then Cr. The position count restarts on every line.
- R4: The pixel clock period is `Np` system cycles. Each period is low for `Np - floor(Np/2)` cycles, then high for `floor(Np/2)` cycles. With `Np = 1` the pixel clock is the inverted system clock.
- R5: The effective `Np` equals `np_cfg`, raised to at least 1 in raw mode and to at least 2 in the two-byte modes.
- R6: When `Np >= 2`, `data_o`, `hsync_o` and `vsync_o` change only in the cycle in which the pixel clock falls.
- R7: `hsync_o` is high only for byte slots that carry pixel data. `data_o` is 0 in every other slot.
- R8: `vsync_o` rises one slot, with `hsync_o` low, before the first byte of a frame. It falls in the slot after the last byte of the frame. Within a frame, lines are separated by exactly one slot in which `hsync_o` is low.
- R9: `mode_cfg` and `np_cfg` are latched when a frame starts. Changes made during a frame have no effect until the next frame.
- R10: `take_o` pulses once per pixel, in the cycle in which the pixel's last byte is loaded. The pixel on the inputs must be held until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pixel present on the inputs |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of a line |
| in_eof | input | 1 | Pixel is the last of a frame |
| in_raw | input | 10 | Raw sensor sample |
| in_c0 | input | 8 | Colour channel 0 (R or Y) |
| in_c1 | input | 8 | Colour channel 1 (G or Cb) |
| in_c2 | input | 8 | Colour channel 2 (B or Cr) |
| mode_cfg | input | 2 | Format code: 0 raw, 1 RGB565, 2 YCbCr 4:2:2, 3 raw |
| np_cfg | input | 4 | Requested pixel clock divider |
| take_o | output | 1 | Current pixel consumed |
| pclk_o | output | 1 | Pixel clock |
| vsync_o | output | 1 | Frame strobe |
| hsync_o | output | 1 | Line strobe, marks valid bytes |
| data_o | output | 8 | Output byte |

## Verification
A new format and divider can be latched in the same slot in which the frame strobe rises. The bench provokes this by programming a different format and divider for every frame, including changes from `Np = 1` to larger dividers and back. It then judges the first byte, the first pixel clock period and the strobe placement against the new settings.

A configuration write can also land in the middle of a frame, while the byte serializer is part-way through a pixel. The bench rewrites the registers right after the first pixel is taken. It requires the remaining bytes and periods to follow the settings latched at frame start.

// File: rtl/cam_fmt_pkg.sv
package cam_fmt_pkg;

    typedef enum logic [1:0] {
        FMT_RAW    = 2'd0,
        FMT_RGB565 = 2'd1,
        FMT_YCC422 = 2'd2,
        FMT_SPARE  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_GAP  = 2'd1,
        SQ_LINE = 2'd2
    } seq_e;

    function automatic logic fmt_two_byte(fmt_e m);
        return (m == FMT_RGB565) || (m == FMT_YCC422);
    endfunction

    function automatic int unsigned fmt_min_np(fmt_e m);
        return fmt_two_byte(m) ? 2 : 1;
    endfunction

endpackage

// File: rtl/cam_fmt_pack.sv
module cam_fmt_pack
    import cam_fmt_pkg::*;
#(
    parameter int RAW_W = 10,
    parameter int CH_W  = 8
) (
    input  fmt_e              mode_i,
    input  logic              odd_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic [CH_W-1:0]   c0_i,
    input  logic [CH_W-1:0]   c1_i,
    input  logic [CH_W-1:0]   c2_i,
    output logic [7:0]        b0_o,
    output logic [7:0]        b1_o,
    output logic              two_o
);
    localparam int OUT_W = 8;

    logic [OUT_W-1:0] raw_top;
    logic [4:0]       r5;
    logic [5:0]       g6;
    logic [4:0]       b5;
    logic [OUT_W-1:0] y8;
    logic [OUT_W-1:0] cb8;
    logic [OUT_W-1:0] cr8;

    assign raw_top = raw_i[RAW_W-1 -: OUT_W];
    assign r5      = c0_i[CH_W-1 -: 5];
    assign g6      = c1_i[CH_W-1 -: 6];
    assign b5      = c2_i[CH_W-1 -: 5];
    assign y8      = c0_i[CH_W-1 -: OUT_W];
    assign cb8     = c1_i[CH_W-1 -: OUT_W];
    assign cr8     = c2_i[CH_W-1 -: OUT_W];

    generate
        if (RAW_W > OUT_W) begin : g_raw_drop
            logic raw_lsb_unused;
            assign raw_lsb_unused = ^raw_i[RAW_W-OUT_W-1:0];
        end
    endgenerate

    always_comb begin
        b0_o  = raw_top;
        b1_o  = '0;
        two_o = 1'b0;
        case (mode_i)
            FMT_RGB565: begin
                b0_o  = {r5, g6[5:3]};
                b1_o  = {g6[2:0], b5};
                two_o = 1'b1;
            end
            FMT_YCC422: begin
                b0_o  = y8;
                b1_o  = odd_i ? cr8 : cb8;
                two_o = 1'b1;
            end
            default: begin
                b0_o  = raw_top;
                b1_o  = '0;
                two_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cam_fmt_pclk.sv
module cam_fmt_pclk #(
    parameter int NP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP_W-1:0] np_i,
    output logic            tick_o,
    output logic            pclk_o,
    output logic            bypass_o
);
    typedef struct packed {
        logic [NP_W-1:0] cnt;
        logic            pclk;
    } dv_t;

    dv_t             dv_d, dv_q;
    logic [NP_W-1:0] lo_len;
    logic            tick;

    always_comb begin
        lo_len   = np_i - (np_i >> 1);
        tick     = (dv_q.cnt >= (np_i - NP_W'(1)));
        dv_d.cnt = tick ? '0 : dv_q.cnt + NP_W'(1);
        dv_d.pclk = (dv_d.cnt >= lo_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign tick_o   = tick;
    assign pclk_o   = dv_q.pclk;
    assign bypass_o = (np_i == NP_W'(1));

    // R4: every period starts with the low phase
    p_low_after_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !dv_q.pclk);

    // R4: the count never leaves the period
    p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.cnt < np_i);

endmodule

// File: rtl/cam_pix_fmt.sv
module cam_pix_fmt
    import cam_fmt_pkg::*;
#(
    parameter int RAW_W = 10,
    parameter int CH_W  = 8,
    parameter int NP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic             in_eof,
    input  logic [RAW_W-1:0] in_raw,
    input  logic [CH_W-1:0]  in_c0,
    input  logic [CH_W-1:0]  in_c1,
    input  logic [CH_W-1:0]  in_c2,
    input  logic [1:0]       mode_cfg,
    input  logic [NP_W-1:0]  np_cfg,
    output logic             take_o,
    output logic             pclk_o,
    output logic             vsync_o,
    output logic             hsync_o,
    output logic [7:0]       data_o
);
    localparam int OUT_W = 8;

    typedef struct packed {
        seq_e            seq;
        logic            vsync;
        logic            hsync;
        logic [OUT_W-1:0] data;
        logic            phase;
        logic            chroma;
        logic            line_end;
        logic            frame_end;
        fmt_e            mode;
        logic [NP_W-1:0] np;
    } st_t;

    st_t              s_d, s_q;
    logic             tick;
    logic             pclk_div;
    logic             bypass;
    logic [OUT_W-1:0] byte0;
    logic [OUT_W-1:0] byte1;
    logic             two_byte;
    logic             take;
    logic             first;
    logic [NP_W-1:0]  np_req;

    function automatic logic [NP_W-1:0] clamp_np(input logic [NP_W-1:0] req, input fmt_e m);
        logic [NP_W-1:0] lim;
        lim = NP_W'(fmt_min_np(m));
        return (req < lim) ? lim : req;
    endfunction

    cam_fmt_pclk #(.NP_W(NP_W)) u_pclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .np_i     (s_q.np),
        .tick_o   (tick),
        .pclk_o   (pclk_div),
        .bypass_o (bypass)
    );

    cam_fmt_pack #(.RAW_W(RAW_W), .CH_W(CH_W)) u_pack (
        .mode_i (s_q.mode),
        .odd_i  (s_q.chroma),
        .raw_i  (in_raw),
        .c0_i   (in_c0),
        .c1_i   (in_c1),
        .c2_i   (in_c2),
        .b0_o   (byte0),
        .b1_o   (byte1),
        .two_o  (two_byte)
    );

    always_comb begin
        s_d    = s_q;
        take   = 1'b0;
        first  = 1'b0;
        np_req = clamp_np(np_cfg, fmt_e'(mode_cfg));
        if (tick) begin
            case (s_q.seq)
                SQ_IDLE: begin
                    s_d.vsync = 1'b0;
                    s_d.hsync = 1'b0;
                    s_d.data  = '0;
                    if (in_valid && in_sof) begin
                        s_d.mode   = fmt_e'(mode_cfg);
                        s_d.np     = np_req;
                        s_d.vsync  = 1'b1;
                        s_d.seq    = SQ_GAP;
                        s_d.chroma = 1'b0;
                        s_d.phase  = 1'b0;
                    end
                end
                SQ_GAP: begin
                    s_d.hsync = 1'b0;
                    s_d.data  = '0;
                    first     = in_valid;
                end
                SQ_LINE: begin
                    if (s_q.phase) begin
                        s_d.hsync = 1'b1;
                        s_d.data  = byte1;
                        s_d.phase = 1'b0;
                        take      = 1'b1;
                    end else if (s_q.frame_end) begin
                        s_d.vsync = 1'b0;
                        s_d.hsync = 1'b0;
                        s_d.data  = '0;
                        s_d.seq   = SQ_IDLE;
                    end else if (s_q.line_end) begin
                        s_d.hsync = 1'b0;
                        s_d.data  = '0;
                        s_d.seq   = SQ_GAP;
                    end else if (in_valid) begin
                        first = 1'b1;
                    end else begin
                        s_d.hsync = 1'b0;
                        s_d.data  = '0;
                    end
                end
                default: begin
                    s_d.seq = SQ_IDLE;
                end
            endcase

            if (first) begin
                s_d.hsync = 1'b1;
                s_d.data  = byte0;
                s_d.seq   = SQ_LINE;
                if (two_byte) begin
                    s_d.phase = 1'b1;
                end else begin
                    take = 1'b1;
                end
            end

            if (take) begin
                s_d.line_end  = in_eol | in_eof;
                s_d.frame_end = in_eof;
                s_d.chroma    = (in_eol | in_eof) ? 1'b0 : ~s_q.chroma;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.seq       <= SQ_IDLE;
            s_q.mode      <= FMT_RAW;
            s_q.np        <= NP_W'(2);
        end else begin
            s_q <= s_d;
        end
    end

    assign take_o  = take;
    assign pclk_o  = bypass ? ~clk : pclk_div;
    assign vsync_o = s_q.vsync;
    assign hsync_o = s_q.hsync;
    assign data_o  = s_q.data;

    // R5: the latched divider respects the floor of the latched format
    p_np_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.np >= NP_W'(1)) && (!fmt_two_byte(s_q.mode) || s_q.np >= NP_W'(2)));

    // R6: bus moves only together with a falling pixel clock
    p_bus_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !$stable(s_q.data)) |-> (!pclk_div && $past(pclk_div)));

    // R7: no data outside the line strobe
    p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.hsync |-> (s_q.data == '0));

    // R8: line strobe only inside the frame strobe
    p_line_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hsync |-> s_q.vsync);

    // R9: format is frozen while a frame is running
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.vsync && $past(s_q.vsync)) |-> ($stable(s_q.mode) && $stable(s_q.np)));

    // R10: one take per slot, never in back-to-back cycles when the slot is longer
    p_take_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bypass) |=> !take);

endmodule

// File: tb/cam_pix_fmt_tb_top.sv
module cam_pix_fmt_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eol = 1'b0;
    logic       in_eof = 1'b0;
    logic [9:0] in_raw = '0;
    logic [7:0] in_c0 = '0;
    logic [7:0] in_c1 = '0;
    logic [7:0] in_c2 = '0;
    logic [1:0] mode_cfg = 2'd0;
    logic [3:0] np_cfg = 4'd2;
    logic       take_o;
    logic       pclk_o;
    logic       vsync_o;
    logic       hsync_o;
    logic [7:0] data_o;

    always #4 clk = ~clk;

    cam_pix_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_eof(in_eof), .in_raw(in_raw), .in_c0(in_c0),
        .in_c1(in_c1), .in_c2(in_c2), .mode_cfg(mode_cfg), .np_cfg(np_cfg),
        .take_o(take_o), .pclk_o(pclk_o), .vsync_o(vsync_o),
        .hsync_o(hsync_o), .data_o(data_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    int  exp_mode = 0;
    int  exp_np = 2;
    bit  mon_en = 1'b0;
    int  lines_seen = 0;
    int  takes_seen = 0;
    bit  frame_done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string mode_req(input int m);
        if (m == 1) return "R2";
        if (m == 2) return "R3";
        return "R1";
    endfunction

    function automatic int exp_div(input int m, input int np);
        int lim;
        lim = (m == 1 || m == 2) ? 2 : 1;
        return (np < lim) ? lim : np;
    endfunction

    // monitor
    logic [9:0] prev_bus = '0;
    logic       prev_pc = 1'b0;
    logic       pvs = 1'b0;
    logic       phs = 1'b0;
    int         cyc_cnt = 0;
    int         hi_cnt = 0;
    bit         rise_ok = 1'b0;

    always @(negedge clk) begin
        logic       pc;
        logic [9:0] bus;
        bit         slot;
        #1;
        pc  = pclk_o;
        bus = {vsync_o, hsync_o, data_o};
        if (rst_n && mon_en) begin
            if (take_o) takes_seen++;
            if (exp_np >= 2 && (vsync_o || prev_bus[9]) && bus != prev_bus)
                chk(!pc && prev_pc, "R6", pc, 0);
            slot = (exp_np == 1) ? 1'b1 : (pc && !prev_pc);
            if (exp_np >= 2) begin
                if (!vsync_o) begin
                    rise_ok = 1'b0;
                end else if (pc && !prev_pc) begin
                    if (rise_ok) begin
                        chk(cyc_cnt == exp_np, "R4 period", cyc_cnt, exp_np);
                        chk(hi_cnt == exp_np / 2, "R4 high phase", hi_cnt, exp_np / 2);
                    end
                    rise_ok = 1'b1;
                    cyc_cnt = 1;
                    hi_cnt  = 1;
                end else begin
                    cyc_cnt++;
                    if (pc) hi_cnt++;
                end
            end
            if (slot && (vsync_o || pvs)) begin
                if (vsync_o && !pvs) chk(!hsync_o, "R8 frame lead slot", hsync_o, 0);
                if (hsync_o) begin
                    chk(vsync_o, "R8 line inside frame", vsync_o, 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, mode_req(exp_mode), data_o, -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(data_o == e, mode_req(exp_mode), data_o, e);
                    end
                    if (!phs) chk(pvs, "R8 gap before line", pvs, 1);
                end else begin
                    chk(data_o == 8'd0, "R7", data_o, 0);
                end
                if (!hsync_o && phs) lines_seen++;
                if (!vsync_o && pvs) begin
                    chk(phs, "R8 frame tail", phs, 1);
                    frame_done = 1'b1;
                end
                pvs = vsync_o;
                phs = hsync_o;
            end
        end
        prev_pc  = pc;
        prev_bus = bus;
    end

    task automatic run_frame(input int mode, input int np, input int lines,
                             input int cols, input bit mid_change);
        logic [9:0] raw_a[0:31];
        logic [7:0] c0_a[0:31];
        logic [7:0] c1_a[0:31];
        logic [7:0] c2_a[0:31];
        int n;
        n = lines * cols;
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            raw_a[i] = 10'($urandom);
            c0_a[i]  = 8'($urandom);
            c1_a[i]  = 8'($urandom);
            c2_a[i]  = 8'($urandom);
            if (mode == 1) begin
                exp_q.push_back({c0_a[i][7:3], c1_a[i][7:5]});
                exp_q.push_back({c1_a[i][4:2], c2_a[i][7:3]});
            end else if (mode == 2) begin
                exp_q.push_back(c0_a[i]);
                exp_q.push_back(((i % cols) % 2 == 0) ? c1_a[i] : c2_a[i]);
            end else begin
                exp_q.push_back(raw_a[i][9:2]);
            end
        end
        exp_mode   = mode;
        exp_np     = exp_div(mode, np);
        mode_cfg   = 2'(mode);
        np_cfg     = 4'(np);
        lines_seen = 0;
        takes_seen = 0;
        frame_done = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit t;
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eol   = ((i % cols) == cols - 1);
            in_eof   = (i == n - 1);
            in_raw   = raw_a[i];
            in_c0    = c0_a[i];
            in_c1    = c1_a[i];
            in_c2    = c2_a[i];
            do begin
                @(negedge clk); #1;
                t = take_o;
                @(posedge clk); #1;
            end while (!t);
            if (mid_change && i == 0) begin
                mode_cfg = 2'((mode + 1) % 3);
                np_cfg   = 4'd1;
            end
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
        in_eof   = 1'b0;
        while (!frame_done) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(lines_seen == lines, "R8 line count", lines_seen, lines);
        chk(takes_seen == n, "R10 takes per frame", takes_seen, n);
        chk(exp_q.size() == 0, mid_change ? "R9 bytes left" : mode_req(mode), exp_q.size(), 0);
        if (exp_np == 1) begin
            @(posedge clk); #1;
            chk(pclk_o == 1'b0, "R4 bypass low", pclk_o, 0);
            @(negedge clk); #1;
            chk(pclk_o == 1'b1, "R4 bypass high", pclk_o, 1);
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5eed_0c41);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!vsync_o, "R8 reset", vsync_o, 0);
        chk(!hsync_o, "R7 reset", hsync_o, 0);
        chk(data_o == 8'd0, "R7 reset data", data_o, 0);
        chk(!take_o, "R10 reset", take_o, 0);
        mon_en = 1'b1;

        run_frame(0, 1, 3, 5, 1'b0);   // R1 raw at full rate
        run_frame(0, 3, 3, 4, 1'b0);   // R4 odd divider
        run_frame(1, 0, 2, 4, 1'b0);   // R2, R5 clamp to 2
        run_frame(2, 1, 3, 5, 1'b0);   // R3 odd line length, R5 clamp
        run_frame(2, 5, 2, 4, 1'b1);   // R9 mid-frame rewrite
        run_frame(1, 4, 2, 3, 1'b1);   // R9 mid-frame rewrite
        run_frame(3, 2, 2, 4, 1'b0);   // R1 spare code acts as raw
        run_frame(0, 0, 2, 3, 1'b0);   // R5 raw clamp to 1
        for (int k = 0; k < 6; k++) begin
            run_frame(int'($urandom_range(3, 0)), int'($urandom_range(15, 0)),
                      int'($urandom_range(4, 2)), int'($urandom_range(6, 2)),
                      bit'($urandom_range(1, 0)));
        end
        done = 1'b1;
        report();
    end

endmodule